// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer for a system-on-chip. Software programs a 16-bit control word that holds an eight-bit timeout code and a set of single-bit controls. After that, software must keep the timer alive. It does this by writing a fixed two-word key pair to a separate service port. If the countdown runs out, the block drives a system-reset pulse. If routing is enabled, it also drives an external reset pulse. Software can also force either reset at once through two active-low control bits.

The countdown advances on a half-second tick input, so timeout code N means an expiry after N+1 ticks. The low-power and debug inputs can each pause the countdown when their suspend bit is set. Once the enable bit is set, software cannot clear it. After an expiry the counter stays stopped until the block itself is reset.

The design is built from three state machines:
- **Key detector.** States `KEY_IDLE` and `KEY_ARMED`. The first key moves it from idle to armed. The second key completes the pair and returns it to idle. Any other write also returns it to idle.
- **Countdown.** States `CNT_STOPPED`, `CNT_RUNNING` and `CNT_EXPIRED`. Setting the enable bit moves it from stopped to running and loads the count. The final tick moves it from running to expired. A completed key pair reloads the count while running.
- **Pulse generator.** States `PLS_QUIET`, `PLS_HOLD` and `PLS_SPENT`. A trigger moves it from quiet to hold. When the hold count runs out it moves to spent.

Top module: `svc_watchdog`

## Requirements
- R1: A write of 0x5555 followed by a write of 0xAAAA on the service port reloads the countdown to the full timeout. Idle cycles may separate the two writes, as long as no other service write falls between them.
- R2: A service write that breaks the key pair returns the detector to idle without a reload. This covers 0xAAAA with no preceding 0x5555, any word other than 0xAAAA after 0x5555, and a repeated 0x5555.
- R3: The timeout code in control bits [15:8] is N. The system reset asserts right after the (N+1)th counted tick following the enable or a reload, and not before.
- R4: While control bit 2 (enable) is 0, ticks have no effect and no timeout reset occurs.
- R5: The control word reads back on `ctl_o` and resets to 0x0030. Bits [7:6] always read 0. Once bit 2 is 1, a write cannot clear it.
- R6: With enable set, a control write with bit 4 = 0 (active-low software reset) asserts `sys_rst_o` in the second cycle after the write. Bit 4 = 0 has no effect while enable is 0.
- R7: Control bit 5 = 0 (active-low external assert) drives `ext_rst_o` high from the cycle after the write, and writing it back to 1 releases the output. It does not touch `sys_rst_o`.
- R8: When control bit 3 is 1, a timeout also pulses `ext_rst_o` together with `sys_rst_o`. When bit 3 is 0, the timeout leaves `ext_rst_o` low.
- R9: While bit 0 is set and `lowpwr_i` is high, ticks are not counted. The same holds while bit 1 is set and `debug_i` is high. With a suspend bit clear, the matching input has no effect.
- R10: A reset pulse lasts exactly PULSE_CYCLES clock cycles, and only one pulse occurs between block resets.
- R11: After a timeout the counter stays stopped. Further ticks and key pairs cause no new reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| ctl_wr_i | input | 1 | Control-word write strobe |
| svc_wr_i | input | 1 | Service-port write strobe |
| wdata_i | input | 16 | Write data for either port |
| tick_i | input | 1 | Half-second countdown tick, one cycle wide |
| lowpwr_i | input | 1 | System is in low-power mode |
| debug_i | input | 1 | System is in debug mode |
| ctl_o | output | 16 | Control word readback |
| sys_rst_o | output | 1 | Internal system reset pulse |
| ext_rst_o | output | 1 | External reset output |

## Verification
A tick counted on the clock edge that takes the count to zero raises `sys_rst_o` right after that same edge. The bench therefore checks it at the falling edge that ends the tick. A software reset passes through the control register and then the pulse state, so it is due one cycle later. The bench samples low at the falling edge right after the write and high one falling edge after that. The external force and the control readback are visible right after the write edge. The timeout sweep counts exactly N ticks and checks the output is still low, then one more tick and checks it is high.

// File: rtl/svc_wdog_pkg.sv
package svc_wdog_pkg;

    localparam int DATA_W = 16;
    localparam int TO_W   = 8;

    typedef struct packed {
        logic [TO_W-1:0] timeout;
        logic [1:0]      rsvd;
        logic            ext_force_n;
        logic            sw_rst_n;
        logic            ext_on_to;
        logic            en;
        logic            dbg_sus;
        logic            lp_sus;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{timeout: '0, rsvd: 2'b00, ext_force_n: 1'b1,
                                   sw_rst_n: 1'b1, ext_on_to: 1'b0, en: 1'b0,
                                   dbg_sus: 1'b0, lp_sus: 1'b0};

    typedef enum logic {KEY_IDLE, KEY_ARMED} key_state_e;
    typedef enum logic [1:0] {CNT_STOPPED, CNT_RUNNING, CNT_EXPIRED} cnt_state_e;
    typedef enum logic [1:0] {PLS_QUIET, PLS_HOLD, PLS_SPENT} pls_state_e;

endpackage

// File: rtl/svc_wdog_keydet.sv
module svc_wdog_keydet
    import svc_wdog_pkg::*;
#(
    parameter int          DW    = 16,
    parameter logic [DW-1:0] KEY_A = 16'h5555,
    parameter logic [DW-1:0] KEY_B = 16'hAAAA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] data,
    output logic          svc_ok
);

    key_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_IDLE:  if (wr && data == KEY_A) state_d = KEY_ARMED;
            KEY_ARMED: if (wr)                  state_d = KEY_IDLE;
            default:                            state_d = KEY_IDLE;
        endcase
    end

    always_comb begin
        svc_ok = (state_q == KEY_ARMED) && wr && (data == KEY_B);
    end

endmodule

// File: rtl/svc_wdog_count.sv
module svc_wdog_count
    import svc_wdog_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          susp,
    input  logic          tick,
    input  logic          reload,
    input  logic [CW-1:0] load_val,
    output logic          fire,
    output logic          expired
);

    cnt_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          step;

    assign step = tick && !susp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_STOPPED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CNT_STOPPED: begin
                if (en) begin
                    state_d = CNT_RUNNING;
                    cnt_d   = load_val;
                end
            end
            CNT_RUNNING: begin
                if (reload) begin
                    cnt_d = load_val;
                end else if (step) begin
                    if (cnt_q == CW'(1)) begin
                        state_d = CNT_EXPIRED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - CW'(1);
                    end
                end
            end
            CNT_EXPIRED: ;
            default: state_d = CNT_STOPPED;
        endcase
    end

    always_comb begin
        fire    = (state_q == CNT_RUNNING) && !reload && step && (cnt_q == CW'(1));
        expired = (state_q == CNT_EXPIRED);
    end

endmodule

// File: rtl/svc_wdog_pulse.sv
module svc_wdog_pulse
    import svc_wdog_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic trig_ext,
    output logic active,
    output logic route_ext
);

    localparam int PW = $clog2(PULSE_CYCLES + 1);

    pls_state_e    state_q, state_d;
    logic [PW-1:0] left_q, left_d;
    logic          ext_q, ext_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PLS_QUIET;
            left_q  <= '0;
            ext_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            ext_q   <= ext_d;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        ext_d   = ext_q;
        unique case (state_q)
            PLS_QUIET: begin
                if (trig) begin
                    state_d = PLS_HOLD;
                    left_d  = PW'(PULSE_CYCLES - 1);
                    ext_d   = trig_ext;
                end
            end
            PLS_HOLD: begin
                if (left_q == '0) begin
                    state_d = PLS_SPENT;
                    ext_d   = 1'b0;
                end else begin
                    left_d = left_q - PW'(1);
                end
            end
            PLS_SPENT: ;
            default: state_d = PLS_QUIET;
        endcase
    end

    always_comb begin
        active    = (state_q == PLS_HOLD);
        route_ext = (state_q == PLS_HOLD) && ext_q;
    end

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
    import svc_wdog_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_i,
    input  logic              svc_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              tick_i,
    input  logic              lowpwr_i,
    input  logic              debug_i,
    output logic [DATA_W-1:0] ctl_o,
    output logic              sys_rst_o,
    output logic              ext_rst_o
);

    localparam int CW = TO_W + 1;

    ctl_t ctl_q, ctl_wr;
    logic svc_ok, tmo_fire, expired, susp, trig, pls_active, pls_ext;
    logic [CW-1:0] load_val;

    assign ctl_wr = ctl_t'(wdata_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else if (ctl_wr_i) begin
            ctl_q      <= ctl_wr;
            ctl_q.rsvd <= 2'b00;
            ctl_q.en   <= ctl_q.en | ctl_wr.en;
        end
    end

    assign susp     = (ctl_q.lp_sus && lowpwr_i) || (ctl_q.dbg_sus && debug_i);
    assign load_val = {1'b0, ctl_q.timeout} + CW'(1);

    svc_wdog_keydet #(.DW(DATA_W)) u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (svc_wr_i),
        .data   (wdata_i),
        .svc_ok (svc_ok)
    );

    svc_wdog_count #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctl_q.en),
        .susp     (susp),
        .tick     (tick_i),
        .reload   (svc_ok),
        .load_val (load_val),
        .fire     (tmo_fire),
        .expired  (expired)
    );

    assign trig = tmo_fire || (ctl_q.en && !ctl_q.sw_rst_n);

    svc_wdog_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pls (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .trig_ext  (tmo_fire && ctl_q.ext_on_to),
        .active    (pls_active),
        .route_ext (pls_ext)
    );

    assign ctl_o     = ctl_q;
    assign sys_rst_o = pls_active;
    assign ext_rst_o = pls_ext || !ctl_q.ext_force_n;

endmodule

// File: rtl/svc_watchdog_chk.sv
module svc_watchdog_chk #(
    parameter int PULSE_CYCLES = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        svc_wr_i,
    input logic [15:0] wdata_i,
    input logic [15:0] ctl_o,
    input logic        sys_rst_o,
    input logic        ext_rst_o,
    input logic        svc_ok,
    input logic        expired
);

    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_cnt <= '0;
        else if (sys_rst_o) hi_cnt <= hi_cnt + 16'd1;
    end

    // R1: a reload only comes with a second-key service write
    assert_reload_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |-> (svc_wr_i && wdata_i == 16'hAAAA));

    // R5: enable stays set
    assert_enable_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o[2] |=> ctl_o[2]);

    // R6: no system reset without enable
    assert_no_rst_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_o[2] |-> !sys_rst_o);

    // R7: forced external output follows the active-low bit
    assert_ext_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_o[5] |-> ext_rst_o);

    // R10: total high time never exceeds one pulse
    assert_pulse_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> (hi_cnt < 16'(PULSE_CYCLES)));

    // R11: expiry is final until reset
    assert_expired_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> expired);

endmodule

bind svc_watchdog svc_watchdog_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .svc_wr_i  (svc_wr_i),
    .wdata_i   (wdata_i),
    .ctl_o     (ctl_o),
    .sys_rst_o (sys_rst_o),
    .ext_rst_o (ext_rst_o),
    .svc_ok    (svc_ok),
    .expired   (expired)
);

// File: tb/svc_watchdog_test.sv
`timescale 1ns/1ps
module svc_watchdog_test;

    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, svc_wr = 1'b0, tick = 1'b0, lowpwr = 1'b0, debug = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] ctl_o;
    logic        sys_rst, ext_rst;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    svc_watchdog #(.PULSE_CYCLES(P)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr), .svc_wr_i(svc_wr),
        .wdata_i(wdata), .tick_i(tick), .lowpwr_i(lowpwr), .debug_i(debug),
        .ctl_o(ctl_o), .sys_rst_o(sys_rst), .ext_rst_o(ext_rst)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lowpwr = 1'b0; debug = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wctl(logic [15:0] v);
        @(negedge clk); ctl_wr = 1'b1; wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wsvc(logic [15:0] v);
        @(negedge clk); svc_wr = 1'b1; wdata = v;
        @(negedge clk); svc_wr = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic start(int n, logic [7:0] bits);
        wctl({n[7:0], 8'h34 | bits});
        wsvc(16'h5555);
        wsvc(16'hAAAA);
    endtask

    task automatic pulse_width(output int w);
        w = 0;
        while (sys_rst && w < 100) begin
            w++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int w;
        do_reset();
        // R5 reset state
        check("R5 reset ctl", ctl_o, 16'h0030);
        check("R5 reset sys", {15'd0, sys_rst}, 16'd0);
        check("R5 reset ext", {15'd0, ext_rst}, 16'd0);

        // R3 and R8: sweep of timeout codes
        for (int n = 0; n < 18; n++) begin
            int code = (n < 16) ? n : (n == 16 ? 127 : 255);
            logic route = n[0];
            do_reset();
            start(code, route ? 8'h08 : 8'h00);
            ticks(code);
            check("R3 before expiry", {15'd0, sys_rst}, 16'd0);
            ticks(1);
            check("R3 at expiry", {15'd0, sys_rst}, 16'd1);
            check("R8 ext routing", {15'd0, ext_rst}, {15'd0, route});
        end

        // R10 width and R11 stopped after expiry
        do_reset();
        start(2, 8'h08);
        ticks(3);
        pulse_width(w);
        check("R10 pulse width", 16'(w), 16'(P));
        wsvc(16'h5555); wsvc(16'hAAAA);
        ticks(10);
        repeat (5) @(negedge clk);
        check("R11 no restart sys", {15'd0, sys_rst}, 16'd0);
        check("R11 no restart ext", {15'd0, ext_rst}, 16'd0);

        // R1 key pair reload, with idle gaps
        do_reset();
        start(3, 8'h00);
        ticks(3);
        wsvc(16'h5555);
        repeat (3) @(negedge clk);
        wsvc(16'hAAAA);
        ticks(3);
        check("R1 reloaded not expired", {15'd0, sys_rst}, 16'd0);
        ticks(1);
        check("R1 expiry after reload", {15'd0, sys_rst}, 16'd1);

        // R2 broken sequences
        for (int k = 0; k < 3; k++) begin
            do_reset();
            start(3, 8'h00);
            ticks(3);
            if (k == 0) begin wsvc(16'h5555); wsvc(16'h1234); wsvc(16'hAAAA); end
            if (k == 1) begin wsvc(16'hAAAA); end
            if (k == 2) begin wsvc(16'h5555); wsvc(16'h5555); wsvc(16'hAAAA); end
            ticks(1);
            check("R2 broken key no reload", {15'd0, sys_rst}, 16'd1);
        end

        // R4 no counting before enable
        do_reset();
        wctl(16'h0030);
        ticks(5);
        check("R4 disabled no reset", {15'd0, sys_rst}, 16'd0);
        wctl(16'h0034);
        ticks(1);
        check("R4 enable then count", {15'd0, sys_rst}, 16'd1);

        // R5 readback, reserved bits, sticky enable
        do_reset();
        wctl(16'h05F7);
        check("R5 readback", ctl_o, 16'h0537);
        wctl(16'h0530);
        check("R5 enable sticky", ctl_o, 16'h0534);
        ticks(5);
        check("R5 still running", {15'd0, sys_rst}, 16'd0);
        ticks(1);
        check("R5 expiry after clear attempt", {15'd0, sys_rst}, 16'd1);

        // R6 software reset
        do_reset();
        wctl(16'h0020);
        repeat (5) @(negedge clk);
        check("R6 ignored when disabled", {15'd0, sys_rst}, 16'd0);
        wctl(16'h0024);
        check("R6 not yet", {15'd0, sys_rst}, 16'd0);
        @(negedge clk);
        check("R6 asserted", {15'd0, sys_rst}, 16'd1);
        check("R6 ext untouched", {15'd0, ext_rst}, 16'd0);
        pulse_width(w);
        check("R10 sw pulse width", 16'(w), 16'(P));

        // R7 external force
        do_reset();
        wctl(16'h0010);
        check("R7 ext forced", {15'd0, ext_rst}, 16'd1);
        check("R7 sys untouched", {15'd0, sys_rst}, 16'd0);
        wctl(16'h0030);
        check("R7 ext released", {15'd0, ext_rst}, 16'd0);

        // R9 suspend modes
        do_reset();
        start(2, 8'h01);
        lowpwr = 1'b1;
        ticks(10);
        check("R9 low-power suspend", {15'd0, sys_rst}, 16'd0);
        lowpwr = 1'b0;
        ticks(2);
        check("R9 resumed not expired", {15'd0, sys_rst}, 16'd0);
        ticks(1);
        check("R9 resumed expiry", {15'd0, sys_rst}, 16'd1);

        do_reset();
        start(2, 8'h02);
        debug = 1'b1;
        ticks(10);
        check("R9 debug suspend", {15'd0, sys_rst}, 16'd0);
        debug = 1'b0;
        ticks(3);
        check("R9 debug resumed expiry", {15'd0, sys_rst}, 16'd1);

        do_reset();
        start(2, 8'h00);
        lowpwr = 1'b1; debug = 1'b1;
        ticks(3);
        check("R9 inputs ignored without bits", {15'd0, sys_rst}, 16'd1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule